// File: doc/BRIEF.md
# Sync Polarity Normaliser

This block accepts a raw synchronisation pulse train of unknown polarity and hands downstream timing logic a pulse that is always positive-going. It brings the input into the clock domain through a short synchronizer chain, then detects both edges of the synchronised level. A measuring state machine counts how many clocks the level stays high and how many it stays low between two consecutive rising edges. When the high time exceeds the low time, the signal is judged active-low (negative polarity), and the output is inverted.

A second state machine filters these per-period judgements. The reported polarity changes only when two periods in a row produce the same verdict and that verdict differs from the current one. This prevents flicker when the duty cycle sits near one half. The block also emits a one-clock strobe at the start of every corrected pulse and another at its end. Both strobes are held off until the first full period has been measured. One instance serves each of the horizontal sync, vertical sync and flyback inputs.

The measuring machine has three states. MS_WAIT waits for the first rising edge and moves to MS_HIGH when it arrives. MS_HIGH counts high clocks and moves to MS_LOW on a falling edge. MS_LOW counts low clocks; on the next rising edge it closes the period and returns to MS_HIGH. The filtering machine has two states. VS_EMPTY means no period has closed yet, and it moves to VS_HELD on the first closed period. VS_HELD holds the last verdict and stays there until reset.

Top module: `sync_pol_norm`

## Requirements
- R1: While reset is asserted and just after release with a low input, `pol_neg`, `lead_stb`, `trail_stb` and `sync_pos` are all 0.
- R2: An input change reaches the synchronised level after exactly `SYNC_STAGES` clock edges (default 2).
- R3: A period runs from one synchronised rising edge to the next. The high count is the number of clocks the synchronised level is 1, and the low count is the number of clocks it is 0. The verdict is negative only when high > low, so an equal split is judged positive.
- R4: `pol_neg` changes only when a period closes with a verdict equal to the verdict of the previous closed period. A single deviating period, or an alternating pattern, leaves it unchanged. The update appears two clocks after the synchronised rising edge that closes the period.
- R5: `pol_neg` = 0 means positive polarity (duty below one half). `pol_neg` = 1 means negative polarity (duty above one half).
- R6: `sync_pos` equals the synchronised level XOR `pol_neg`.
- R7: `lead_stb` pulses for one clock when `sync_pos` goes 0→1, and `trail_stb` pulses for one clock when it goes 1→0. These correspond to a synchronised rising edge when `pol_neg`=0 and a falling edge when `pol_neg`=1, and the reverse for `trail_stb`.
- R8: No strobe is issued until the first period has closed. Strobes become enabled in the same clock in which that first verdict is registered.
- R9: The high and low counters saturate at 2^`CNT_W`−1 and never wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync_in | input | 1 | Raw sync or flyback level, either polarity, asynchronous |
| sync_pos | output | 1 | Synchronised level corrected to positive-going pulses |
| pol_neg | output | 1 | Polarity status: 0 positive, 1 negative |
| lead_stb | output | 1 | One-clock strobe at the start of a corrected pulse |
| trail_stb | output | 1 | One-clock strobe at the end of a corrected pulse |

## Verification
The assertions assume that every period contains at least one clock high and one clock low after synchronisation. This guarantees that a period-closed pulse can never appear on two clocks in a row. The edge-shape checks are also skipped in any clock where the polarity bit itself moves. The stimulus changes `sync_in` one time unit after a rising clock edge and holds every level for whole clock counts of at least one. It covers low-duty trains, high-duty trains, a single outlier period, alternating near-half periods, an exact half split, and periods longer than the counter range with a reduced `CNT_W`.

// File: rtl/spf_pkg.sv
package spf_pkg;

    // Period measurement machine
    typedef enum logic [1:0] {
        MS_WAIT = 2'd0,   // no rising edge seen yet
        MS_HIGH = 2'd1,   // counting clocks with the level high
        MS_LOW  = 2'd2    // counting clocks with the level low
    } meter_st_t;

    // Verdict filter machine
    typedef enum logic {
        VS_EMPTY = 1'b0,  // no period closed yet
        VS_HELD  = 1'b1   // a previous verdict is held
    } vote_st_t;

endpackage

// File: rtl/spf_sync.sv
// Multi-stage synchronizer for an asynchronous level.
module spf_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    localparam int LAST = STAGES - 1;

    logic [LAST:0] chain;

    generate
        genvar gi;
        for (gi = 0; gi <= LAST; gi++) begin : g_stage
            if (gi == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[gi] <= 1'b0;
                    else        chain[gi] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[gi] <= 1'b0;
                    else        chain[gi] <= chain[gi-1];
                end
            end
        end
    endgenerate

    assign q = chain[LAST];

endmodule

// File: rtl/spf_edge.sv
// Edge detector: one-clock pulses on both edges of a synchronous level.
module spf_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl,
    output logic rise,
    output logic fall
);
    logic lvl_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lvl_d <= 1'b0;
        else        lvl_d <= lvl;
    end

    assign rise = lvl & ~lvl_d;
    assign fall = ~lvl & lvl_d;

endmodule

// File: rtl/spf_meter.sv
// Measures high and low clocks between consecutive rising edges and
// delivers a registered verdict once per closed period.
module spf_meter
    import spf_pkg::*;
#(
    parameter int CNT_W = 12
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rise,
    input  logic fall,
    output logic per_done,
    output logic per_neg
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    meter_st_t       st_q, st_nx;
    logic [CNT_W-1:0] hi_q, hi_nx;
    logic [CNT_W-1:0] lo_q, lo_nx;
    logic             close_per;

    function automatic logic [CNT_W-1:0] sat_inc(input logic [CNT_W-1:0] v);
        return (v == CNT_MAX) ? v : v + CNT_ONE;
    endfunction

    // Next state and counter values
    always_comb begin
        st_nx     = st_q;
        hi_nx     = hi_q;
        lo_nx     = lo_q;
        close_per = 1'b0;
        unique case (st_q)
            MS_WAIT: begin
                if (rise) begin
                    st_nx = MS_HIGH;
                    hi_nx = CNT_ONE;
                    lo_nx = '0;
                end
            end
            MS_HIGH: begin
                if (fall) begin
                    st_nx = MS_LOW;
                    lo_nx = CNT_ONE;
                end else begin
                    hi_nx = sat_inc(hi_q);
                end
            end
            MS_LOW: begin
                if (rise) begin
                    close_per = 1'b1;
                    st_nx     = MS_HIGH;
                    hi_nx     = CNT_ONE;
                    lo_nx     = '0;
                end else begin
                    lo_nx = sat_inc(lo_q);
                end
            end
            default: begin
                st_nx = MS_WAIT;
                hi_nx = '0;
                lo_nx = '0;
            end
        endcase
    end

    // State and counter registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= MS_WAIT;
            hi_q <= '0;
            lo_q <= '0;
        end else begin
            st_q <= st_nx;
            hi_q <= hi_nx;
            lo_q <= lo_nx;
        end
    end

    // Registered verdict outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            per_done <= 1'b0;
            per_neg  <= 1'b0;
        end else begin
            per_done <= close_per;
            if (close_per) per_neg <= (hi_q > lo_q);
        end
    end

    // A period needs at least one high and one low clock
    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        per_done |=> !per_done);  // R3

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == MS_HIGH && !fall && hi_q == CNT_MAX) |=> (hi_q == CNT_MAX));  // R9

    AST_NO_OVERFLOW_LO: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == MS_LOW && !rise && lo_q == CNT_MAX) |=> (lo_q == CNT_MAX));  // R9

endmodule

// File: rtl/spf_vote.sv
// Two-in-a-row filter on period verdicts; owns the polarity bit.
module spf_vote
    import spf_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic per_done,
    input  logic per_neg,
    output logic pol,
    output logic armed
);
    vote_st_t vst_q, vst_nx;
    logic     cand_q;

    // State transition
    always_comb begin
        vst_nx = vst_q;
        unique case (vst_q)
            VS_EMPTY: if (per_done) vst_nx = VS_HELD;
            VS_HELD:  vst_nx = VS_HELD;
            default:  vst_nx = VS_EMPTY;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) vst_q <= VS_EMPTY;
        else        vst_q <= vst_nx;
    end

    // Outputs: held verdict and polarity bit
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cand_q <= 1'b0;
            pol    <= 1'b0;
        end else if (per_done) begin
            cand_q <= per_neg;
            if (vst_q == VS_HELD && cand_q == per_neg) pol <= per_neg;
        end
    end

    assign armed = (vst_q == VS_HELD);

    AST_POL_NEEDS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(pol) |-> $past(per_done));  // R4

    AST_POL_TWO_AGREE: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(pol) |-> ($past(cand_q) == pol && $past(per_neg) == pol));  // R4

    AST_ARMED_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        armed |=> armed);  // R8

endmodule

// File: rtl/sync_pol_norm.sv
// Sync polarity normaliser: synchronise, detect edges, measure duty,
// filter the verdict and present a positive-going pulse with strobes.
module sync_pol_norm #(
    parameter int CNT_W       = 12,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sync_in,
    output logic sync_pos,
    output logic pol_neg,
    output logic lead_stb,
    output logic trail_stb
);
    logic lvl;
    logic rise, fall;
    logic per_done, per_neg;
    logic armed;

    spf_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (sync_in),
        .q     (lvl)
    );

    spf_edge u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .lvl   (lvl),
        .rise  (rise),
        .fall  (fall)
    );

    spf_meter #(.CNT_W(CNT_W)) u_meter (
        .clk      (clk),
        .rst_n    (rst_n),
        .rise     (rise),
        .fall     (fall),
        .per_done (per_done),
        .per_neg  (per_neg)
    );

    spf_vote u_vote (
        .clk      (clk),
        .rst_n    (rst_n),
        .per_done (per_done),
        .per_neg  (per_neg),
        .pol      (pol_neg),
        .armed    (armed)
    );

    // Corrected level and polarity-aware strobes
    assign sync_pos  = lvl ^ pol_neg;
    assign lead_stb  = armed & (pol_neg ? fall : rise);
    assign trail_stb = armed & (pol_neg ? rise : fall);

    AST_LEAD_IS_START: assert property (@(posedge clk) disable iff (!rst_n)
        (lead_stb && $stable(pol_neg)) |-> (sync_pos && !$past(sync_pos)));  // R7

    AST_TRAIL_IS_END: assert property (@(posedge clk) disable iff (!rst_n)
        (trail_stb && $stable(pol_neg)) |-> (!sync_pos && $past(sync_pos)));  // R7

    AST_STB_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(lead_stb && trail_stb));  // R7

endmodule

// File: tb/sync_pol_norm_test.sv
module sync_pol_norm_test;
    localparam int CW   = 4;
    localparam int MAXC = 15;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic raw = 1'b0;
    logic sync_pos, pol_neg, lead_stb, trail_stb;

    int n_run = 0, n_fail = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    sync_pol_norm #(.CNT_W(CW), .SYNC_STAGES(2)) uut (
        .clk(clk), .rst_n(rst_n), .sync_in(raw),
        .sync_pos(sync_pos), .pol_neg(pol_neg),
        .lead_stb(lead_stb), .trail_stb(trail_stb)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // ---------------- behavioural reference ----------------
    bit m_h0, m_h1, m_h2;
    int m_state, m_hi, m_lo, cyc;
    bit m_pol, m_armed, m_have, m_cand;
    int due_t[$];
    bit due_d[$];

    always @(posedge clk) begin
        if (!rst_n) begin
            m_h0 = 0; m_h1 = 0; m_h2 = 0;
            m_state = 0; m_hi = 0; m_lo = 0; cyc = 0;
            m_pol = 0; m_armed = 0; m_have = 0; m_cand = 0;
            due_t.delete(); due_d.delete();
        end else begin
            bit rs, fl, d;
            cyc++;
            m_h2 = m_h1; m_h1 = m_h0; m_h0 = raw;
            while (due_t.size() > 0 && due_t[0] == cyc) begin
                d = due_d.pop_front();
                void'(due_t.pop_front());
                if (m_have && m_cand == d) m_pol = d;
                m_cand = d; m_have = 1; m_armed = 1;
            end
            rs = m_h1 && !m_h2;
            fl = !m_h1 && m_h2;
            if (m_state == 0) begin
                if (rs) begin m_state = 1; m_hi = 1; m_lo = 0; end
            end else if (m_state == 1) begin
                if (fl) begin m_state = 2; m_lo = 1; end
                else if (m_hi < MAXC) m_hi++;
            end else begin
                if (rs) begin
                    due_t.push_back(cyc + 2);
                    due_d.push_back(m_hi > m_lo);
                    m_state = 1; m_hi = 1; m_lo = 0;
                end else if (m_lo < MAXC) m_lo++;
            end
        end
    end

    // ---------------- per-clock comparison ----------------
    int lead_cnt = 0, trail_cnt = 0, pol_chg = 0;
    bit pol_prev = 0;

    always @(negedge clk) begin
        if (rst_n && !finished) begin
            bit rs, fl, el, et;
            rs = m_h1 && !m_h2;
            fl = !m_h1 && m_h2;
            el = m_armed && (m_pol ? fl : rs);
            et = m_armed && (m_pol ? rs : fl);
            chk(sync_pos == (m_h1 ^ m_pol), "R2 R6 sync_pos", sync_pos, m_h1 ^ m_pol);
            chk(pol_neg == m_pol, "R4 R5 pol_neg", pol_neg, m_pol);
            chk(lead_stb == el, "R7 R8 lead_stb", lead_stb, el);
            chk(trail_stb == et, "R7 R8 trail_stb", trail_stb, et);
            if (lead_stb) lead_cnt++;
            if (trail_stb) trail_cnt++;
            if (pol_neg != pol_prev) pol_chg++;
            pol_prev = pol_neg;
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic hold(input bit v, input int c);
        raw = v;
        repeat (c) @(posedge clk);
        #1;
    endtask

    task automatic periods(input int h, input int l, input int n);
        for (int i = 0; i < n; i++) begin
            hold(1'b1, h);
            hold(1'b0, l);
        end
    endtask

    task automatic close_wait();
        hold(1'b1, 1);
        hold(1'b0, 6);
    endtask

    // ---------------- watchdog ----------------
    initial begin
        #(200000 * 10);
        if (!finished) begin
            n_run++; n_fail++;
            $display("FAIL watchdog expired actual=1 expected=0");
            finished = 1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    // ---------------- main sequence ----------------
    initial begin
        raw = 0;
        repeat (3) @(posedge clk);
        #1;
        // R1: reset state while still in reset
        chk(pol_neg == 0 && lead_stb == 0 && trail_stb == 0 && sync_pos == 0,
            "R1 outputs in reset", {pol_neg, lead_stb, trail_stb, sync_pos}, 0);
        rst_n = 1;
        hold(1'b0, 8);
        chk(pol_neg == 0 && lead_stb == 0 && trail_stb == 0 && sync_pos == 0,
            "R1 outputs after release", {pol_neg, lead_stb, trail_stb, sync_pos}, 0);

        // R2: latency of exactly two edges
        raw = 1;
        @(posedge clk); #1;
        chk(sync_pos == 0, "R2 after one edge", sync_pos, 0);
        @(posedge clk); #1;
        chk(sync_pos == 1, "R2 after two edges", sync_pos, 1);
        hold(1'b1, 1);
        hold(1'b0, 9);

        // R8: no strobes before first closed period
        chk(lead_cnt == 0 && trail_cnt == 0, "R8 no strobe in first period",
            lead_cnt + trail_cnt, 0);

        // Positive train
        lead_cnt = 0; trail_cnt = 0;
        periods(3, 9, 3);
        close_wait();
        chk(pol_neg == 0, "R5 low duty gives positive", pol_neg, 0);
        chk(lead_cnt >= 2, "R7 lead strobes issued", lead_cnt, 2);
        chk(trail_cnt >= 2, "R7 trail strobes issued", trail_cnt, 2);

        // Negative train
        periods(10, 3, 4);
        close_wait();
        chk(pol_neg == 1, "R5 high duty gives negative", pol_neg, 1);

        // R4: single outlier must not flip
        pol_chg = 0;
        periods(10, 3, 3);
        periods(2, 9, 1);
        periods(10, 3, 2);
        close_wait();
        chk(pol_chg == 0, "R4 single outlier ignored", pol_chg, 0);
        chk(pol_neg == 1, "R4 polarity held", pol_neg, 1);

        // R3: equal split judged positive
        periods(10, 3, 3);
        periods(5, 5, 3);
        close_wait();
        chk(pol_neg == 0, "R3 equal split positive", pol_neg, 0);

        // R4: alternating near-half periods
        pol_chg = 0;
        for (int k = 0; k < 3; k++) begin
            periods(6, 5, 1);
            periods(5, 6, 1);
        end
        close_wait();
        chk(pol_chg == 0, "R4 alternation ignored", pol_chg, 0);
        chk(pol_neg == 0, "R4 alternation keeps positive", pol_neg, 0);

        // R9: saturation makes long 20/18 periods compare equal
        periods(10, 3, 3);
        periods(20, 18, 3);
        close_wait();
        chk(pol_neg == 0, "R9 saturated counts compare equal", pol_neg, 0);

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule